// File: doc/BRIEF.md
# Threshold-Gated Transmit FIFO with Credit Return

This block is a single-channel transmit buffer. A DMA engine writes into it, and a streaming consumer reads from it. The DMA engine moves data in bursts of a fixed length. Before it starts a burst, it asks the block for admission. The block keeps a pool of credits that starts at the FIFO depth. It admits a burst only when the pool still covers every word of that burst, and it then removes the burst length from the pool.

On the read side, the FIFO holds its contents back until the fill level reaches a programmable threshold. The threshold is set independently of the burst length, so several bursts may have to land before the first word leaves. Once the gate opens, the consumer drains one word per valid/ready handshake until the FIFO is empty. The gate then closes again. Each drained word produces a one-cycle credit pulse, and the pool grows by one.

The writer combines credits with the known depth, so it never overruns the storage. A write that arrives while the FIFO is full is discarded and raises a sticky error flag. Fill level and available credits are reported as status outputs.

Top module: `gated_credit_fifo`

## Requirements
- R1: After reset, fill_o is 0, credits_o equals DEPTH, rd_valid_o is 0, overflow_o is 0 and burst_ready_o is 1.
- R2: burst_ready_o is high exactly when credits_o is at least BURST_LEN. A cycle with burst_req_i and burst_ready_o both high, and no credit pulse, lowers credits_o by BURST_LEN on the next cycle. A request made while burst_ready_o is low leaves credits_o unchanged.
- R3: A write (wr_valid_i high) while fill_o equals DEPTH is discarded. fill_o stays at DEPTH, the discarded word never appears on rd_data_o, and overflow_o goes high on the next cycle and stays high until reset.
- R4: rd_valid_o stays low while the FIFO is filling from empty and fill_o is below the effective threshold. It goes high in the cycle after the write that brings fill_o to the effective threshold.
- R5: Once rd_valid_o has gone high, it stays high while fill_o is nonzero, even below the threshold. After the FIFO empties, rd_valid_o stays low until the threshold is reached again.
- R6: The effective threshold is thresh_i clamped to DEPTH. A threshold above DEPTH opens the gate when the FIFO is full.
- R7: credit_o is high in exactly the cycles where rd_valid_o and rd_ready_i are both high. Without a simultaneous admission, each such pulse raises credits_o by one on the next cycle. rd_ready_i with rd_valid_o low produces no pulse and removes no word.
- R8: credits_o never exceeds DEPTH, and a credit pulse while credits_o equals DEPTH leaves it at DEPTH. An admission in the same cycle as a credit pulse changes credits_o by 1 minus BURST_LEN.
- R9: Words leave on rd_data_o in the order they were accepted.
- R10: fill_o rises by one on an accepted write and falls by one on a drain. It is unchanged when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| thresh_i | input | CNT_W | Drain threshold in words (clamped to DEPTH) |
| burst_req_i | input | 1 | Writer asks to start a burst |
| burst_ready_o | output | 1 | Enough credits for a whole burst |
| wr_valid_i | input | 1 | Write strobe for one word |
| wr_data_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | Word available to the consumer |
| rd_ready_i | input | 1 | Consumer accepts a word |
| rd_data_o | output | DATA_W | Head-of-FIFO data |
| credit_o | output | 1 | One-cycle credit pulse per drained word |
| fill_o | output | CNT_W | Current fill level |
| credits_o | output | CNT_W | Credits available to the writer |
| overflow_o | output | 1 | Sticky write-while-full error |

## Verification
The hardest states to reach are at the edges of the credit pool. One is an admission that lands in the same cycle as a returned credit, exactly when the pool holds one burst. Another is a full FIFO that still receives a write. A well-behaved writer never produces either. The bench reaches them with two deliberate violations. It admits bursts until the pool is empty and then fills the FIFO to the top with data it never asked credits for. It then drains four words, so the pool holds exactly one burst, and raises a request in the same cycle as the next drain. It also pushes words without admission into an idle pool, so that returned credits meet the DEPTH ceiling.

// File: rtl/gcf_pkg.sv
package gcf_pkg;

    // Drain gate state: shut until the threshold is met, open until empty.
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

    // Width that can hold every value from 0 to depth inclusive.
    function automatic int cnt_w_f(input int depth);
        return $clog2(depth + 1);
    endfunction

    // Address width for a storage array of the given depth.
    function automatic int addr_w_f(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/gcf_store.sv
module gcf_store
    import gcf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = cnt_w_f(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o
);
    localparam int AW = addr_w_f(DEPTH);
    localparam logic [AW-1:0]    LAST_A  = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CNT_W-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wp = (st_q.wp == LAST_A) ? '0 : st_q.wp + AW'(1);
        end
        if (pop_i) begin
            st_d.rp = (st_q.rp == LAST_A) ? '0 : st_q.rp + AW'(1);
        end
        unique case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_i) begin
            mem_q[st_q.wp] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[st_q.rp];
    assign count_o   = st_q.cnt;
    assign full_o    = (st_q.cnt == DEPTH_C);

endmodule

// File: rtl/gcf_drain_gate.sv
module gcf_drain_gate
    import gcf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = cnt_w_f(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             drain_ok_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        gate_e state;
    } gate_t;

    gate_t g_d, g_q;
    logic [CNT_W-1:0] thr_eff;
    logic             reached;
    logic             pass;
    logic             empties;

    always_comb begin
        thr_eff  = (thresh_i > DEPTH_C) ? DEPTH_C : thresh_i;
        reached  = (count_i >= thr_eff);
        pass     = (g_q.state == GATE_OPEN) || reached;
        empties  = pop_i && !push_i && (count_i == CNT_W'(1));
        g_d      = g_q;
        if (empties) begin
            g_d.state = GATE_SHUT;
        end else if (pass && (count_i != '0 || push_i)) begin
            g_d.state = GATE_OPEN;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            g_q <= '{state: GATE_SHUT};
        end else begin
            g_q <= g_d;
        end
    end

    assign drain_ok_o = pass && (count_i != '0);

endmodule

// File: rtl/gcf_credit_ctr.sv
module gcf_credit_ctr
    import gcf_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = cnt_w_f(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             ret_i,
    output logic             ready_o,
    output logic [CNT_W-1:0] credits_o
);
    localparam int SW = CNT_W + 1;
    localparam logic [SW-1:0] DEPTH_S = SW'(DEPTH);
    localparam logic [SW-1:0] BURST_S = SW'(BURST_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] credits;
    } cred_t;

    cred_t c_d, c_q;
    logic [SW-1:0] sum;
    logic          admit;

    always_comb begin
        ready_o = ({1'b0, c_q.credits} >= BURST_S);
        admit   = req_i && ready_o;
        sum     = {1'b0, c_q.credits};
        if (ret_i) begin
            sum = sum + SW'(1);
        end
        if (admit) begin
            sum = sum - BURST_S;
        end
        if (sum > DEPTH_S) begin
            sum = DEPTH_S;
        end
        c_d.credits = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q.credits <= CNT_W'(DEPTH);
        end else begin
            c_q <= c_d;
        end
    end

    assign credits_o = c_q.credits;

endmodule

// File: rtl/gated_credit_fifo.sv
module gated_credit_fifo
    import gcf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 32,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = cnt_w_f(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic              burst_req_i,
    output logic              burst_ready_o,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              credit_o,
    output logic [CNT_W-1:0]  fill_o,
    output logic [CNT_W-1:0]  credits_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic ovf;
    } top_t;

    top_t t_d, t_q;
    logic full;
    logic push;
    logic pop;
    logic drain_ok;
    logic [CNT_W-1:0] count;

    always_comb begin
        push = wr_valid_i && !full;
        pop  = drain_ok && rd_ready_i;
        t_d  = t_q;
        if (wr_valid_i && full) begin
            t_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    gcf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (push),
        .pop_i     (pop),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .count_o   (count),
        .full_o    (full)
    );

    gcf_drain_gate #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_gate (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .thresh_i   (thresh_i),
        .count_i    (count),
        .push_i     (push),
        .pop_i      (pop),
        .drain_ok_o (drain_ok)
    );

    gcf_credit_ctr #(
        .DEPTH     (DEPTH),
        .BURST_LEN (BURST_LEN),
        .CNT_W     (CNT_W)
    ) u_credit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (burst_req_i),
        .ret_i     (pop),
        .ready_o   (burst_ready_o),
        .credits_o (credits_o)
    );

    assign rd_valid_o = drain_ok;
    assign credit_o   = pop;
    assign fill_o     = count;
    assign overflow_o = t_q.ovf;

endmodule

// File: rtl/gcf_checker.sv
module gcf_checker
    import gcf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 32,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = cnt_w_f(DEPTH)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CNT_W-1:0]  thresh_i,
    input logic              burst_req_i,
    input logic              burst_ready_o,
    input logic              wr_valid_i,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic              credit_o,
    input logic [CNT_W-1:0]  fill_o,
    input logic [CNT_W-1:0]  credits_o,
    input logic              overflow_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST_LEN);

    logic [CNT_W-1:0] thr_eff;
    assign thr_eff = (thresh_i > DEPTH_C) ? DEPTH_C : thresh_i;

    p_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_ready_o |-> (credits_o >= BURST_C));

    p_admit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_req_i && burst_ready_o && !credit_o) |=>
            (credits_o == $past(credits_o) - BURST_C));

    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |=> overflow_o);

    p_full_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_i && fill_o == DEPTH_C) |=> overflow_o);

    p_gate_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_valid_o) |-> (fill_o >= thr_eff));

    p_drain_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !(rd_ready_i && fill_o == CNT_W'(1))) |=> rd_valid_o);

    p_credit_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (credit_o && !(burst_req_i && burst_ready_o) && credits_o != DEPTH_C) |=>
            (credits_o == $past(credits_o) + CNT_W'(1)));

    p_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        credits_o <= DEPTH_C);

    p_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_o <= DEPTH_C);

endmodule

bind gated_credit_fifo gcf_checker #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .BURST_LEN (BURST_LEN),
    .CNT_W     (CNT_W)
) u_gcf_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .thresh_i      (thresh_i),
    .burst_req_i   (burst_req_i),
    .burst_ready_o (burst_ready_o),
    .wr_valid_i    (wr_valid_i),
    .rd_valid_o    (rd_valid_o),
    .rd_ready_i    (rd_ready_i),
    .credit_o      (credit_o),
    .fill_o        (fill_o),
    .credits_o     (credits_o),
    .overflow_o    (overflow_o)
);

// File: tb/gated_credit_fifo_tb_top.sv
module gated_credit_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int DEP   = 16;
    localparam int BL    = 4;
    localparam int CW    = $clog2(DEP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] thresh = CW'(8);
    logic          burst_req = 1'b0;
    logic          burst_ready;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic          credit;
    logic [CW-1:0] fill;
    logic [CW-1:0] credits;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    int exp_cred = DEP;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gated_credit_fifo #(
        .DATA_W    (DW),
        .DEPTH     (DEP),
        .BURST_LEN (BL)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .thresh_i      (thresh),
        .burst_req_i   (burst_req),
        .burst_ready_o (burst_ready),
        .wr_valid_i    (wr_valid),
        .wr_data_i     (wr_data),
        .rd_valid_o    (rd_valid),
        .rd_ready_i    (rd_ready),
        .rd_data_o     (rd_data),
        .credit_o      (credit),
        .fill_o        (fill),
        .credits_o     (credits),
        .overflow_o    (overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Inputs change just after a falling edge; results are read one falling edge later.
    task automatic admit();
        burst_req = 1'b1;
        #1 chk("R2 ready before admit", int'(burst_ready), 1);
        @(negedge clk);
        burst_req = 1'b0;
        exp_cred -= BL;
        chk("R2 credits after admit", int'(credits), exp_cred);
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pop(input logic [DW-1:0] d, input string tag);
        rd_ready = 1'b1;
        #1;
        chk({tag, " R5 valid"}, int'(rd_valid), 1);
        chk({tag, " R9 data"}, int'(rd_data), int'(d));
        chk({tag, " R7 credit pulse"}, int'(credit), 1);
        @(negedge clk);
        rd_ready = 1'b0;
        exp_cred = (exp_cred + 1 > DEP) ? DEP : exp_cred + 1;
        chk({tag, " R7 R8 credits"}, int'(credits), exp_cred);
    endtask

    task automatic t_reset();
        chk("R1 fill", int'(fill), 0);
        chk("R1 credits", int'(credits), DEP);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 burst_ready", int'(burst_ready), 1);
    endtask

    task automatic t_threshold();
        thresh = CW'(8);
        admit();
        admit();
        for (int i = 0; i < 8; i++) begin
            push(DW'(16'h100 + i));
            if (i < 7) chk("R4 held below threshold", int'(rd_valid), 0);
        end
        chk("R4 opens at threshold", int'(rd_valid), 1);
        chk("R10 fill after pushes", int'(fill), 8);
        for (int i = 0; i < 8; i++) pop(DW'(16'h100 + i), "drain1");
        chk("R5 shut when empty", int'(rd_valid), 0);
        chk("R10 fill empty", int'(fill), 0);
        // refill below threshold: gate must stay shut
        admit();
        admit();
        push(16'h120);
        push(16'h121);
        chk("R5 rearm held", int'(rd_valid), 0);
        rd_ready = 1'b1;
        #1 chk("R7 no pulse while held", int'(credit), 0);
        @(negedge clk);
        rd_ready = 1'b0;
        chk("R7 no word removed", int'(fill), 2);
        for (int i = 2; i < 8; i++) push(DW'(16'h120 + i));
        chk("R5 rearm opens", int'(rd_valid), 1);
        for (int i = 0; i < 8; i++) pop(DW'(16'h120 + i), "drain2");
        chk("R8 pool refilled", int'(credits), DEP);
    endtask

    task automatic t_cap();
        thresh = CW'(2);
        push(16'h140);
        push(16'h141);
        pop(16'h140, "cap");
        pop(16'h141, "cap");
        chk("R8 capped at depth", int'(credits), DEP);
        thresh = CW'(8);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 4; i++) admit();
        chk("R2 ready low when pool empty", int'(burst_ready), 0);
        burst_req = 1'b1;
        @(negedge clk);
        burst_req = 1'b0;
        chk("R2 refused request no change", int'(credits), 0);
        for (int i = 0; i < DEP; i++) push(DW'(16'h200 + i));
        chk("R10 full", int'(fill), DEP);
        chk("R3 no overflow yet", int'(overflow), 0);
        push(16'hDEAD);
        chk("R3 overflow set", int'(overflow), 1);
        chk("R3 fill stays full", int'(fill), DEP);
        for (int i = 0; i < 4; i++) pop(DW'(16'h200 + i), "ovf");
        chk("R2 ready with one burst", int'(burst_ready), 1);
        // admission and credit return in the same cycle
        burst_req = 1'b1;
        rd_ready  = 1'b1;
        #1 chk("R9 data at combined", int'(rd_data), 16'h204);
        @(negedge clk);
        burst_req = 1'b0;
        rd_ready  = 1'b0;
        exp_cred  = exp_cred - BL + 1;
        chk("R8 combined admit and credit", int'(credits), exp_cred);
        for (int i = 5; i < DEP; i++) pop(DW'(16'h200 + i), "ovf tail");
        chk("R3 dropped word absent", int'(rd_valid), 0);
        chk("R3 overflow sticky", int'(overflow), 1);
    endtask

    task automatic t_clamp();
        thresh = CW'(31);
        for (int i = 0; i < DEP - 1; i++) push(DW'(16'h300 + i));
        chk("R6 held at depth-1", int'(rd_valid), 0);
        push(DW'(16'h300 + DEP - 1));
        chk("R6 opens when full", int'(rd_valid), 1);
        for (int i = 0; i < DEP; i++) pop(DW'(16'h300 + i), "clamp");
    endtask

    task automatic t_simul();
        thresh = CW'(1);
        push(16'h400);
        chk("R10 one word", int'(fill), 1);
        wr_valid = 1'b1;
        wr_data  = 16'h401;
        rd_ready = 1'b1;
        #1 chk("R9 head before swap", int'(rd_data), 16'h400);
        @(negedge clk);
        wr_valid = 1'b0;
        rd_ready = 1'b0;
        exp_cred = (exp_cred + 1 > DEP) ? DEP : exp_cred + 1;
        chk("R10 push and pop same cycle", int'(fill), 1);
        pop(16'h401, "simul");
        chk("R10 empty at end", int'(fill), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_cap();
        t_overflow();
        t_clamp();
        t_simul();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule